// File: doc/BRIEF.md
# Prefetch Read Buffer Controller

This block keeps a handful of software-managed prefetch entries next to a data cache. A requester issues an allocate command that names an entry, a word address and a fill size. The block accepts it in one cycle and fetches one word, or a whole four-word block, over a simple beat interface in the background. Later loads look the buffer up first. A hit returns buffered data. A miss tells the cache path to serve the load instead.

Each entry holds a block tag, four data words, a valid bit per word, an abort flag and a busy flag. Only one bus fill runs at a time. The block keeps a word from being valid in two entries at once by evicting any other entry that overlaps a new allocation. Bus errors are recorded against the entry and reported only when a load hits it. Snooped writes leave the buffer untouched. Software can invalidate one entry or every entry.

Addresses are word addresses. The low two bits give the word within a block, and the remaining bits are the block tag.

Top module: `prb_ctrl`

## Requirements
- R1: With no fill active, `alloc_ready` is 1 and a fault-free allocate is accepted in that cycle. On the next cycle `fill_req` is 1, and it stays 1 until the last beat is taken. No load is held back by the allocate itself.
- R2: An allocate accepted with `alloc_fault`=1 starts no fill (`fill_req` stays 0) and leaves every entry as it was.
- R3: With `alloc_full`=1 the fill asks for the whole block: `fill_addr` is the block base (low two bits 0), `fill_full`=1, four beats are taken and all four words become valid. With `alloc_full`=0, `fill_addr` is the allocate address and one beat is taken. Only that word becomes valid.
- R4: When an allocate covers a word that is valid in a different entry with the same tag, that other entry is invalidated completely. A word never counts as valid in two entries.
- R5: An allocate to an entry invalidates all of its old words before filling, whatever address the entry held. Repeating an allocate with the same entry and address starts a second fill.
- R6: While a fill is active, `alloc_ready` is 0. A load whose block tag matches the entry being filled sees `ld_ready`=0 and gets neither hit nor miss.
- R7: For an accepted load (`ld_valid` and `ld_ready`), exactly one of `ld_hit`/`ld_miss` is 1. `ld_words` shows which words of the addressed block the buffer holds, and on a hit `ld_data` is the buffered word.
- R8: A beat with `beat_err`=1 does not stop the fill, which still takes all of its beats. A later load hitting that entry gets `ld_abort`=1 with `ld_data`=0.
- R9: A write seen on `wr_valid`/`wr_addr` changes no buffered data and no valid bit.
- R10: A one-cycle `inv_one` clears the entry named by `inv_entry`. A one-cycle `inv_all` clears every entry. Other entries keep their words.
- R11: `beat_ready` is 1 exactly while a fill is active. Beats fill words in ascending order starting at the word of `fill_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate command present |
| alloc_ready | output | 1 | Allocate can be accepted this cycle |
| alloc_entry | input | 2 | Target entry index |
| alloc_addr | input | 16 | Word address to prefetch |
| alloc_full | input | 1 | 1 = whole block, 0 = one word |
| alloc_fault | input | 1 | Translation flagged an access violation |
| ld_valid | input | 1 | Load lookup present |
| ld_ready | output | 1 | Lookup answered this cycle (0 = stall) |
| ld_addr | input | 16 | Load word address |
| ld_hit | output | 1 | Word is held in the buffer |
| ld_miss | output | 1 | Word must come from cache or memory |
| ld_words | output | 4 | Buffered words of the addressed block |
| ld_data | output | 32 | Buffered data on a hit |
| ld_abort | output | 1 | Hit entry carries a bus abort |
| fill_req | output | 1 | Bus fill active |
| fill_addr | output | 16 | First word address of the fill |
| fill_full | output | 1 | Fill is a whole block |
| beat_valid | input | 1 | Bus beat present |
| beat_ready | output | 1 | Beat accepted |
| beat_data | input | 32 | Beat data |
| beat_err | input | 1 | Bus error on this beat |
| inv_one | input | 1 | Invalidate one entry |
| inv_entry | input | 2 | Entry to invalidate |
| inv_all | input | 1 | Invalidate all entries |
| wr_valid | input | 1 | Snooped write present |
| wr_addr | input | 16 | Snooped write word address |

## Verification
The allocate path is tried with four patterns: a full-block fill, a single-word fill at a mid-block offset, a faulted allocate, and repeated allocates to one entry. Together they separate the fill-size rules from the invalidate-before-fill rule and from the no-op rule. The load path is tried against a complete block, against a partial block where the neighbouring word must miss, against a block still being filled where the lookup must stall, and against an entry that took a bus error. A second allocate that overlaps a partial entry shows whether the older copy is evicted. A write to a held word, followed by a load from the same word, shows whether snooped writes really leave the contents alone.

// File: rtl/prb_pkg.sv
package prb_pkg;
  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_RUN  = 1'b1
  } fill_st_e;
endpackage

// File: rtl/prb_fill_seq.sv
module prb_fill_seq
  import prb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int ENTRIES = 4,
  parameter int WPB     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [$clog2(ENTRIES)-1:0] start_entry,
  input  logic [ADDR_W-1:0]          start_addr,
  input  logic                       start_full,
  input  logic                       beat_valid,
  output logic                       active,
  output logic                       beat_fire,
  output logic                       last_beat,
  output logic [$clog2(WPB)-1:0]     beat_idx,
  output logic [$clog2(ENTRIES)-1:0] tgt_entry,
  output logic [ADDR_W-1:0]          fill_addr,
  output logic                       fill_full
);
  localparam int WB = $clog2(WPB);
  localparam int EB = $clog2(ENTRIES);

  fill_st_e          st_q, st_n;
  logic [EB-1:0]     tgt_q, tgt_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              full_q, full_n;
  logic [WB-1:0]     idx_q, idx_n;

  assign active    = (st_q == FILL_RUN);
  assign beat_fire = active && beat_valid;
  assign last_beat = !full_q || (idx_q == WB'(WPB - 1));
  assign beat_idx  = idx_q;
  assign tgt_entry = tgt_q;
  assign fill_addr = addr_q;
  assign fill_full = full_q;

  always_comb begin
    st_n   = st_q;
    tgt_n  = tgt_q;
    addr_n = addr_q;
    full_n = full_q;
    idx_n  = idx_q;
    if (start) begin
      st_n   = FILL_RUN;
      tgt_n  = start_entry;
      full_n = start_full;
      addr_n = start_full ? {start_addr[ADDR_W-1:WB], {WB{1'b0}}} : start_addr;
      idx_n  = start_full ? '0 : start_addr[WB-1:0];
    end else if (beat_fire) begin
      if (last_beat) st_n = FILL_IDLE;
      else           idx_n = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FILL_IDLE;
      tgt_q  <= '0;
      addr_q <= '0;
      full_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      st_q   <= st_n;
      tgt_q  <= tgt_n;
      addr_q <= addr_n;
      full_q <= full_n;
      idx_q  <= idx_n;
    end
  end
endmodule

// File: rtl/prb_entry.sv
module prb_entry #(
  parameter int TAG_W  = 14,
  parameter int DATA_W = 32,
  parameter int WPB    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   start,
  input  logic [TAG_W-1:0]       start_tag,
  input  logic                   we,
  input  logic [$clog2(WPB)-1:0] we_idx,
  input  logic [DATA_W-1:0]      we_data,
  input  logic                   we_err,
  input  logic                   done,
  output logic [TAG_W-1:0]       tag,
  output logic [WPB-1:0]         wv,
  output logic                   aborted,
  output logic                   busy,
  output logic [WPB*DATA_W-1:0]  data_flat
);
  logic [TAG_W-1:0]  tag_q, tag_n;
  logic [WPB-1:0]    wv_q, wv_n;
  logic              ab_q, ab_n;
  logic              busy_q, busy_n;
  logic [DATA_W-1:0] data_q [WPB];

  always_comb begin
    tag_n  = tag_q;
    wv_n   = wv_q;
    ab_n   = ab_q;
    busy_n = busy_q;
    if (clr) begin
      wv_n = '0;
      ab_n = 1'b0;
    end
    if (we) begin
      wv_n[we_idx] = 1'b1;
      ab_n         = ab_n | we_err;
    end
    if (done) busy_n = 1'b0;
    if (start) begin
      tag_n  = start_tag;
      wv_n   = '0;
      ab_n   = 1'b0;
      busy_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      wv_q   <= '0;
      ab_q   <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      tag_q  <= tag_n;
      wv_q   <= wv_n;
      ab_q   <= ab_n;
      busy_q <= busy_n;
    end
  end

  always_ff @(posedge clk) begin
    if (we) data_q[we_idx] <= we_data;
  end

  for (genvar w = 0; w < WPB; w++) begin : g_flat
    assign data_flat[w*DATA_W +: DATA_W] = data_q[w];
  end

  assign tag     = tag_q;
  assign wv      = wv_q;
  assign aborted = ab_q;
  assign busy    = busy_q;
endmodule

// File: rtl/prb_lookup.sv
module prb_lookup #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 4,
  parameter int WPB     = 4
) (
  input  logic [ADDR_W-1:0]                        ld_addr,
  input  logic [ENTRIES*(ADDR_W-$clog2(WPB))-1:0] tags_flat,
  input  logic [ENTRIES*WPB-1:0]                   wv_flat,
  input  logic [ENTRIES-1:0]                       ab_vec,
  input  logic [ENTRIES-1:0]                       busy_vec,
  input  logic [ENTRIES*WPB*DATA_W-1:0]            data_flat,
  output logic                                     stall,
  output logic                                     hit,
  output logic [WPB-1:0]                           words,
  output logic [DATA_W-1:0]                        data,
  output logic                                     abort
);
  localparam int WB    = $clog2(WPB);
  localparam int TAG_W = ADDR_W - WB;

  logic [TAG_W-1:0] ld_tag;
  logic [WB-1:0]    ld_word;
  assign ld_tag  = ld_addr[ADDR_W-1:WB];
  assign ld_word = ld_addr[WB-1:0];

  always_comb begin
    stall = 1'b0;
    hit   = 1'b0;
    words = '0;
    data  = '0;
    abort = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (tags_flat[e*TAG_W +: TAG_W] == ld_tag) begin
        stall = stall | busy_vec[e];
        words = words | wv_flat[e*WPB +: WPB];
        if (wv_flat[e*WPB + int'(ld_word)]) begin
          hit   = 1'b1;
          abort = abort | ab_vec[e];
          data  = data | data_flat[(e*WPB + int'(ld_word))*DATA_W +: DATA_W];
        end
      end
    end
  end
endmodule

// File: rtl/prb_ctrl.sv
module prb_ctrl #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 4,
  parameter int WPB     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_valid,
  output logic                       alloc_ready,
  input  logic [$clog2(ENTRIES)-1:0] alloc_entry,
  input  logic [ADDR_W-1:0]          alloc_addr,
  input  logic                       alloc_full,
  input  logic                       alloc_fault,
  input  logic                       ld_valid,
  output logic                       ld_ready,
  input  logic [ADDR_W-1:0]          ld_addr,
  output logic                       ld_hit,
  output logic                       ld_miss,
  output logic [WPB-1:0]             ld_words,
  output logic [DATA_W-1:0]          ld_data,
  output logic                       ld_abort,
  output logic                       fill_req,
  output logic [ADDR_W-1:0]          fill_addr,
  output logic                       fill_full,
  input  logic                       beat_valid,
  output logic                       beat_ready,
  input  logic [DATA_W-1:0]          beat_data,
  input  logic                       beat_err,
  input  logic                       inv_one,
  input  logic [$clog2(ENTRIES)-1:0] inv_entry,
  input  logic                       inv_all,
  input  logic                       wr_valid,
  input  logic [ADDR_W-1:0]          wr_addr
);
  localparam int WB    = $clog2(WPB);
  localparam int EB    = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - WB;

  logic                        fill_active, beat_fire, last_beat;
  logic [WB-1:0]               beat_idx;
  logic [EB-1:0]               tgt_entry;
  logic                        alloc_go;
  logic [TAG_W-1:0]            alloc_tag;
  logic [WPB-1:0]              alloc_mask;
  logic [ENTRIES*TAG_W-1:0]    e_tag_flat;
  logic [ENTRIES*WPB-1:0]      e_wv_flat;
  logic [ENTRIES*WPB*DATA_W-1:0] e_data_flat;
  logic [ENTRIES-1:0]          e_ab, e_busy;
  logic                        lk_stall, lk_hit, lk_abort;
  logic [WPB-1:0]              lk_words;
  logic [DATA_W-1:0]           lk_data;

  assign alloc_ready = !fill_active;
  assign alloc_go    = alloc_valid && alloc_ready && !alloc_fault;
  assign alloc_tag   = alloc_addr[ADDR_W-1:WB];
  assign alloc_mask  = alloc_full ? {WPB{1'b1}} : (WPB'(1) << alloc_addr[WB-1:0]);

  prb_fill_seq #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .WPB(WPB)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (alloc_go),
    .start_entry (alloc_entry),
    .start_addr  (alloc_addr),
    .start_full  (alloc_full),
    .beat_valid  (beat_valid),
    .active      (fill_active),
    .beat_fire   (beat_fire),
    .last_beat   (last_beat),
    .beat_idx    (beat_idx),
    .tgt_entry   (tgt_entry),
    .fill_addr   (fill_addr),
    .fill_full   (fill_full)
  );

  assign fill_req   = fill_active;
  assign beat_ready = fill_active;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic is_tgt, evict, clr, start, we;
    assign is_tgt = (alloc_entry == EB'(e));
    assign evict  = alloc_go && !is_tgt
                    && (e_tag_flat[e*TAG_W +: TAG_W] == alloc_tag)
                    && |(e_wv_flat[e*WPB +: WPB] & alloc_mask);
    assign clr    = inv_all || (inv_one && inv_entry == EB'(e)) || evict;
    assign start  = alloc_go && is_tgt;
    assign we     = beat_fire && (tgt_entry == EB'(e));

    prb_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W), .WPB(WPB)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .start     (start),
      .start_tag (alloc_tag),
      .we        (we),
      .we_idx    (beat_idx),
      .we_data   (beat_data),
      .we_err    (beat_err),
      .done      (we && last_beat),
      .tag       (e_tag_flat[e*TAG_W +: TAG_W]),
      .wv        (e_wv_flat[e*WPB +: WPB]),
      .aborted   (e_ab[e]),
      .busy      (e_busy[e]),
      .data_flat (e_data_flat[e*WPB*DATA_W +: WPB*DATA_W])
    );
  end

  prb_lookup #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES), .WPB(WPB)) u_lk (
    .ld_addr   (ld_addr),
    .tags_flat (e_tag_flat),
    .wv_flat   (e_wv_flat),
    .ab_vec    (e_ab),
    .busy_vec  (e_busy),
    .data_flat (e_data_flat),
    .stall     (lk_stall),
    .hit       (lk_hit),
    .words     (lk_words),
    .data      (lk_data),
    .abort     (lk_abort)
  );

  assign ld_ready = !lk_stall;
  assign ld_hit   = ld_valid && !lk_stall && lk_hit;
  assign ld_miss  = ld_valid && !lk_stall && !lk_hit;
  assign ld_abort = ld_hit && lk_abort;
  assign ld_data  = (ld_hit && !lk_abort) ? lk_data : '0;
  assign ld_words = (ld_valid && !lk_stall) ? lk_words : '0;
endmodule

// File: rtl/prb_ctrl_chk.sv
module prb_ctrl_chk #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 4,
  parameter int WPB     = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          alloc_valid,
  input logic                          alloc_ready,
  input logic                          alloc_fault,
  input logic                          ld_valid,
  input logic                          ld_ready,
  input logic                          ld_hit,
  input logic                          ld_miss,
  input logic                          ld_abort,
  input logic [DATA_W-1:0]             ld_data,
  input logic                          fill_req,
  input logic                          beat_valid,
  input logic                          beat_ready,
  input logic                          inv_one,
  input logic                          inv_all,
  input logic                          wr_valid,
  input logic [ADDR_W-1:0]             wr_addr,
  input logic [ENTRIES*(ADDR_W-$clog2(WPB))-1:0] e_tag_flat,
  input logic [ENTRIES*WPB-1:0]        e_wv_flat,
  input logic [ENTRIES*WPB*DATA_W-1:0] e_data_flat
);
  localparam int WB    = $clog2(WPB);
  localparam int TAG_W = ADDR_W - WB;

  logic wr_held;
  always_comb begin
    wr_held = 1'b0;
    for (int e = 0; e < ENTRIES; e++)
      if (e_tag_flat[e*TAG_W +: TAG_W] == wr_addr[ADDR_W-1:WB]
          && e_wv_flat[e*WPB + int'(wr_addr[WB-1:0])])
        wr_held = 1'b1;
  end

  p_alloc_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ready && !alloc_fault |=> fill_req);

  p_fault_noop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ready && alloc_fault |=> !fill_req && $stable(e_wv_flat));

  p_alloc_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !alloc_ready);

  p_load_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !ld_ready |-> !ld_hit && !ld_miss);

  p_hit_xor_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_ready |-> (ld_hit != ld_miss));

  p_abort_no_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_abort |-> ld_hit && (ld_data == '0));

  p_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_held && !alloc_valid && !beat_valid && !inv_one && !inv_all
    |=> $stable(e_wv_flat) && $stable(e_data_flat));

  p_inv_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all && !fill_req |=> (e_wv_flat == '0));

  p_fill_end_on_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fill_req) |-> $past(beat_valid && beat_ready));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_i
    for (genvar j = i + 1; j < ENTRIES; j++) begin : g_j
      p_word_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (e_tag_flat[i*TAG_W +: TAG_W] == e_tag_flat[j*TAG_W +: TAG_W])
        |-> ((e_wv_flat[i*WPB +: WPB] & e_wv_flat[j*WPB +: WPB]) == '0));
    end
  end
endmodule

bind prb_ctrl prb_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES), .WPB(WPB)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_valid (alloc_valid),
  .alloc_ready (alloc_ready),
  .alloc_fault (alloc_fault),
  .ld_valid    (ld_valid),
  .ld_ready    (ld_ready),
  .ld_hit      (ld_hit),
  .ld_miss     (ld_miss),
  .ld_abort    (ld_abort),
  .ld_data     (ld_data),
  .fill_req    (fill_req),
  .beat_valid  (beat_valid),
  .beat_ready  (beat_ready),
  .inv_one     (inv_one),
  .inv_all     (inv_all),
  .wr_valid    (wr_valid),
  .wr_addr     (wr_addr),
  .e_tag_flat  (e_tag_flat),
  .e_wv_flat   (e_wv_flat),
  .e_data_flat (e_data_flat)
);

// File: tb/tb_prb_ctrl.sv
module tb_prb_ctrl;
  logic        clk, rst_n;
  logic        alloc_valid, alloc_ready, alloc_full, alloc_fault;
  logic [1:0]  alloc_entry;
  logic [15:0] alloc_addr;
  logic        ld_valid, ld_ready, ld_hit, ld_miss, ld_abort;
  logic [15:0] ld_addr;
  logic [3:0]  ld_words;
  logic [31:0] ld_data;
  logic        fill_req, fill_full, beat_valid, beat_ready, beat_err;
  logic [15:0] fill_addr;
  logic [31:0] beat_data;
  logic        inv_one, inv_all, wr_valid;
  logic [1:0]  inv_entry;
  logic [15:0] wr_addr;

  int total = 0;
  int bad   = 0;

  prb_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_entry(alloc_entry),
    .alloc_addr(alloc_addr), .alloc_full(alloc_full), .alloc_fault(alloc_fault),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_hit(ld_hit),
    .ld_miss(ld_miss), .ld_words(ld_words), .ld_data(ld_data), .ld_abort(ld_abort),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_full(fill_full),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_data(beat_data),
    .beat_err(beat_err), .inv_one(inv_one), .inv_entry(inv_entry), .inv_all(inv_all),
    .wr_valid(wr_valid), .wr_addr(wr_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] dval(input logic [15:0] salt, input logic [15:0] a);
    return {salt, a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic alloc(input logic [1:0] e, input logic [15:0] a,
                       input logic full, input logic fault);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_entry = e; alloc_addr = a;
    alloc_full = full; alloc_fault = fault;
    while (!alloc_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    alloc_valid = 1'b0; alloc_fault = 1'b0;
  endtask

  task automatic feed(input int n, input logic [15:0] first, input logic [15:0] salt,
                      input int err_at, output int taken);
    taken = 0;
    for (int i = 0; i < n; i++) begin
      beat_valid = 1'b1;
      beat_data  = dval(salt, first + 16'(i));
      beat_err   = (i == err_at);
      #1;
      if (beat_ready) taken++;
      @(posedge clk);
      @(negedge clk);
    end
    beat_valid = 1'b0; beat_err = 1'b0;
  endtask

  task automatic load(input logic [15:0] a);
    ld_valid = 1'b1; ld_addr = a;
    #1;
  endtask

  task automatic unload();
    ld_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(alloc_ready && !fill_req && !beat_ready, "R1", "idle after reset",
        {alloc_ready, fill_req, beat_ready}, 3'b100);
    load(16'h0100);
    chk(ld_miss && !ld_hit && ld_words == 4'h0, "R7", "empty buffer misses",
        {ld_hit, ld_miss, ld_words}, 6'b010000);
    unload();
  endtask

  task automatic t_full_fill();
    int n;
    alloc(2'd0, 16'h0102, 1'b1, 1'b0);
    chk(fill_req && fill_full && fill_addr == 16'h0100, "R3", "block fill request",
        {fill_req, fill_full, fill_addr}, {2'b11, 16'h0100});
    feed(4, 16'h0100, 16'h1111, -1, n);
    chk(n == 4 && !fill_req, "R11", "four beats then idle", {n[7:0], fill_req}, {8'd4, 1'b0});
    load(16'h0102);
    chk(ld_hit && ld_data == dval(16'h1111, 16'h0102) && ld_words == 4'hF, "R7",
        "block hit data", {ld_hit, ld_words, ld_data}, {1'b1, 4'hF, dval(16'h1111, 16'h0102)});
    unload();
  endtask

  task automatic t_single_fill();
    int n;
    alloc(2'd1, 16'h0205, 1'b0, 1'b0);
    chk(fill_req && !fill_full && fill_addr == 16'h0205, "R3", "single word request",
        {fill_req, fill_full, fill_addr}, {2'b10, 16'h0205});
    feed(1, 16'h0205, 16'h1212, -1, n);
    chk(!fill_req, "R3", "one beat ends fill", fill_req, 0);
    load(16'h0205);
    chk(ld_hit && ld_words == 4'b0010 && ld_data == dval(16'h1212, 16'h0205), "R3",
        "single word hit", {ld_hit, ld_words, ld_data}, {1'b1, 4'b0010, dval(16'h1212, 16'h0205)});
    unload();
    load(16'h0206);
    chk(ld_miss && !ld_hit && ld_words == 4'b0010, "R7", "neighbour word misses",
        {ld_hit, ld_miss, ld_words}, 6'b010010);
    unload();
  endtask

  task automatic t_fault();
    alloc(2'd0, 16'h0300, 1'b1, 1'b1);
    chk(!fill_req && alloc_ready, "R2", "faulted allocate starts no fill",
        {fill_req, alloc_ready}, 2'b01);
    load(16'h0101);
    chk(ld_hit && ld_data == dval(16'h1111, 16'h0101), "R2", "entry kept old data",
        {ld_hit, ld_data}, {1'b1, dval(16'h1111, 16'h0101)});
    unload();
  endtask

  task automatic t_stall();
    int n;
    alloc(2'd2, 16'h0400, 1'b1, 1'b0);
    chk(!alloc_ready, "R6", "allocate blocked during fill", alloc_ready, 0);
    load(16'h0401);
    chk(!ld_ready && !ld_hit && !ld_miss, "R6", "load to filling block stalls",
        {ld_ready, ld_hit, ld_miss}, 3'b000);
    ld_valid = 1'b0;
    load(16'h0101);
    chk(ld_ready && ld_hit, "R1", "other loads served during fill", {ld_ready, ld_hit}, 2'b11);
    ld_valid = 1'b0;
    feed(4, 16'h0400, 16'h2222, -1, n);
    load(16'h0401);
    chk(ld_ready && ld_hit && ld_data == dval(16'h2222, 16'h0401), "R6",
        "load served after fill", {ld_ready, ld_hit, ld_data}, {2'b11, dval(16'h2222, 16'h0401)});
    unload();
  endtask

  task automatic t_evict();
    int n;
    alloc(2'd3, 16'h0204, 1'b1, 1'b0);
    feed(4, 16'h0204, 16'h3333, -1, n);
    load(16'h0205);
    chk(ld_hit && ld_words == 4'hF && ld_data == dval(16'h3333, 16'h0205), "R4",
        "overlapping entry evicted", {ld_hit, ld_words, ld_data}, {1'b1, 4'hF, dval(16'h3333, 16'h0205)});
    unload();
    load(16'h0103);
    chk(ld_hit && ld_data == dval(16'h1111, 16'h0103), "R4", "unrelated entry kept",
        {ld_hit, ld_data}, {1'b1, dval(16'h1111, 16'h0103)});
    unload();
  endtask

  task automatic t_realloc();
    int n;
    alloc(2'd0, 16'h0501, 1'b0, 1'b0);
    feed(1, 16'h0501, 16'h4444, -1, n);
    load(16'h0102);
    chk(ld_miss && !ld_hit, "R5", "old words dropped on reallocate", {ld_hit, ld_miss}, 2'b01);
    unload();
    alloc(2'd0, 16'h0501, 1'b0, 1'b0);
    chk(fill_req && fill_addr == 16'h0501, "R5", "repeat allocate fills again",
        {fill_req, fill_addr}, {1'b1, 16'h0501});
    feed(1, 16'h0501, 16'h5555, -1, n);
    load(16'h0501);
    chk(ld_hit && ld_data == dval(16'h5555, 16'h0501), "R5", "second fill data",
        {ld_hit, ld_data}, {1'b1, dval(16'h5555, 16'h0501)});
    unload();
  endtask

  task automatic t_abort();
    int n;
    alloc(2'd1, 16'h0600, 1'b1, 1'b0);
    feed(4, 16'h0600, 16'h6666, 1, n);
    chk(n == 4 && !fill_req, "R8", "fill completes despite error",
        {n[7:0], fill_req}, {8'd4, 1'b0});
    load(16'h0603);
    chk(ld_hit && ld_abort && ld_data == 32'h0, "R8", "load reports abort",
        {ld_hit, ld_abort, ld_data}, {2'b11, 32'h0});
    unload();
  endtask

  task automatic t_write();
    wr_valid = 1'b1; wr_addr = 16'h0401;
    @(posedge clk); @(negedge clk);
    wr_valid = 1'b0;
    load(16'h0401);
    chk(ld_hit && ld_data == dval(16'h2222, 16'h0401), "R9", "write leaves buffer",
        {ld_hit, ld_data}, {1'b1, dval(16'h2222, 16'h0401)});
    unload();
  endtask

  task automatic t_inval();
    inv_one = 1'b1; inv_entry = 2'd2;
    @(posedge clk); @(negedge clk);
    inv_one = 1'b0;
    load(16'h0401);
    chk(ld_miss && !ld_hit, "R10", "selected entry cleared", {ld_hit, ld_miss}, 2'b01);
    unload();
    load(16'h0205);
    chk(ld_hit, "R10", "other entry survives", ld_hit, 1);
    unload();
    inv_all = 1'b1;
    @(posedge clk); @(negedge clk);
    inv_all = 1'b0;
    load(16'h0205);
    chk(ld_miss && !ld_hit, "R10", "all cleared (e3)", {ld_hit, ld_miss}, 2'b01);
    unload();
    load(16'h0501);
    chk(ld_miss && !ld_hit, "R10", "all cleared (e0)", {ld_hit, ld_miss}, 2'b01);
    unload();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    alloc_valid = 0; alloc_entry = 0; alloc_addr = 0; alloc_full = 0; alloc_fault = 0;
    ld_valid = 0; ld_addr = 0; beat_valid = 0; beat_data = 0; beat_err = 0;
    inv_one = 0; inv_entry = 0; inv_all = 0; wr_valid = 0; wr_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_fill();
    t_single_fill();
    t_fault();
    t_stall();
    t_evict();
    t_realloc();
    t_abort();
    t_write();
    t_inval();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule